// File: doc/BRIEF.md
# Audio Path Selector with Loopback Receiver

This block decides where the samples for an on-chip audio DAC come from. A 4-bit routing code picks one of three paths. The first is direct: stereo samples from the disc decoder pass straight to the DAC, and the chip's serial audio output pins are released to high impedance. The second is loopback: those output pins are driven so that audio can leave the chip, and a three-wire serial input (bit clock, data, word clock) is deserialized to feed the DAC instead. The third covers every other code, which leaves the DAC with zero samples and no strobe.

The loopback receiver always takes 16-bit words at one sample per frame, MSB first. It follows the framing style chosen for the output port by the 4-bit output format code. An I2S-style format means the word clock is low for left and the MSB arrives one bit clock after the word clock edge. Any other format means the word clock is high for left and the MSB comes on the first bit clock of each half frame. The serial pins are oversampled by the system clock through a synchronizer, so the bit clock must run well below the system clock. Direct routing is only honoured for output formats that the DAC can take unchanged.

Top module: `audio_route_sel`

## Requirements
- R1: With routing code 0010 and an output format code of 1010, 1011, 1110 or 0010, every cycle with `dec_valid` high presents that left/right pair on `dac_left`/`dac_right`, with `dac_valid` high, one clock later.
- R2: With any routing code other than 0000, all four bits of `ser_out_oe` are low one clock later (bit 3 bit clock, bit 2 word clock, bit 1 data, bit 0 error flag).
- R3: With routing code 0000, all four bits of `ser_out_oe` are high one clock later.
- R4: In loopback, each frame of a 16-bit left word followed by a 16-bit right word, MSB first, sampled on rising bit clock edges, gives exactly one `dac_valid` pulse that carries both words. The first frame after loopback is entered is discarded.
- R5: Output format codes 1010, 1110, 1100 and 1111 select I2S-style loopback framing (word clock low = left, MSB one bit clock after the word clock edge). All other codes select the style with word clock high = left and the MSB on the first bit clock of the half frame.
- R6: Routing code 0010 with any output format code outside {1010, 1011, 1110, 0010} holds `dac_left`/`dac_right` at zero with `dac_valid` low.
- R7: Any routing code other than 0000 and 0010 holds `dac_left`/`dac_right` at zero with `dac_valid` low.
- R8: In loopback the decoder inputs have no effect on the DAC outputs, and in direct mode the serial input pins have no effect on them.
- R9: After reset, `dac_valid` is low, `dac_left`/`dac_right` are zero and `ser_out_oe` is 0000.
- R10: A loopback `dac_valid` pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also oversamples the serial input |
| rst_n | input | 1 | Active-low asynchronous reset |
| route_code | input | 4 | DAC source routing code |
| fmt_code | input | 4 | Output port format code |
| dec_left | input | SAMPLE_W | Decoder left sample |
| dec_right | input | SAMPLE_W | Decoder right sample |
| dec_valid | input | 1 | Decoder pair strobe |
| ser_bclk_in | input | 1 | Serial input bit clock |
| ser_ws_in | input | 1 | Serial input word clock |
| ser_data_in | input | 1 | Serial input data |
| dac_left | output | SAMPLE_W | Left sample toward the DAC |
| dac_right | output | SAMPLE_W | Right sample toward the DAC |
| dac_valid | output | 1 | One-cycle strobe for a new pair |
| ser_out_oe | output | 4 | Output enables for the serial output pins |

## Verification
The assertions check on every cycle that direct mode forwards each decoder pair one clock later, that the pin enables follow the routing code, that refused or unknown routes keep the DAC outputs at zero, and that loopback strobes last one cycle and only appear when the receiver completes a pair. The bench scenarios are what show that serial words come out bit-exact in both framing styles, that the first loopback frame is dropped, and that each path ignores the other path's inputs. Each of these needs whole frames of stimulus compared against a scoreboard.

// File: rtl/audio_route_pkg.sv
package audio_route_pkg;

   localparam int ROUTE_W = 4;
   localparam int FMT_W   = 4;
   localparam int PIN_N   = 4;

   localparam logic [ROUTE_W-1:0] ROUTE_LOOP   = 4'b0000;
   localparam logic [ROUTE_W-1:0] ROUTE_DIRECT = 4'b0010;

   typedef enum logic [1:0] {
      PATH_OFF,
      PATH_DIRECT,
      PATH_LOOP
   } path_e;

   typedef enum logic {
      FRAME_PLAIN,
      FRAME_I2S
   } frame_e;

   function automatic path_e route_decode(input logic [ROUTE_W-1:0] code,
                                          input logic direct_ok);
      path_e p;
      if (code == ROUTE_LOOP)                     p = PATH_LOOP;
      else if (code == ROUTE_DIRECT && direct_ok) p = PATH_DIRECT;
      else                                        p = PATH_OFF;
      return p;
   endfunction

endpackage

// File: rtl/ar_fmt_decode.sv
module ar_fmt_decode
   import audio_route_pkg::*;
(
   input  logic [FMT_W-1:0] fmt_code,
   output frame_e           frame,
   output logic             direct_ok
);

   always_comb begin
      frame     = FRAME_PLAIN;
      direct_ok = 1'b0;
      case (fmt_code)
         4'b1010: begin frame = FRAME_I2S;   direct_ok = 1'b1; end
         4'b1011: begin frame = FRAME_PLAIN; direct_ok = 1'b1; end
         4'b1110: begin frame = FRAME_I2S;   direct_ok = 1'b1; end
         4'b0010: begin frame = FRAME_PLAIN; direct_ok = 1'b1; end
         4'b1100: frame = FRAME_I2S;
         4'b1111: frame = FRAME_I2S;
         default: frame = FRAME_PLAIN;
      endcase
   end

endmodule

// File: rtl/ar_sync.sv
module ar_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ar_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/ar_lb_deser.sv
module ar_lb_deser
   import audio_route_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  frame_e              frame,
   input  logic                bclk_s,
   input  logic                ws_s,
   input  logic                sd_s,
   output logic [SAMPLE_W-1:0] pair_left,
   output logic [SAMPLE_W-1:0] pair_right,
   output logic                pair_stb
);

   localparam int CNT_W = $clog2(SAMPLE_W + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_W - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SAMPLE_W);

   logic                bclk_d;
   logic                ws_prev;
   logic                chan_last;
   logic                seen;
   logic                locked;
   logic [CNT_W-1:0]    cnt;
   logic [SAMPLE_W-1:0] sr;
   logic [SAMPLE_W-1:0] left_hold;
   logic                have_left;

   logic                rise;
   logic                chan;
   logic                is_left;
   logic                word_done;
   logic [SAMPLE_W-1:0] word_next;

   always_comb begin
      rise      = bclk_s & ~bclk_d;
      chan      = (frame == FRAME_I2S) ? ws_prev : ws_s;
      is_left   = (frame == FRAME_I2S) ? ~chan : chan;
      word_next = {sr[SAMPLE_W-2:0], sd_s};
      word_done = seen && locked && (chan == chan_last) && (cnt == CNT_LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_d <= 1'b0;
      else        bclk_d <= bclk_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ws_prev    <= 1'b0;
         chan_last  <= 1'b0;
         seen       <= 1'b0;
         locked     <= 1'b0;
         cnt        <= '0;
         sr         <= '0;
         left_hold  <= '0;
         have_left  <= 1'b0;
         pair_left  <= '0;
         pair_right <= '0;
         pair_stb   <= 1'b0;
      end else if (!enable) begin
         ws_prev   <= 1'b0;
         chan_last <= 1'b0;
         seen      <= 1'b0;
         locked    <= 1'b0;
         cnt       <= '0;
         have_left <= 1'b0;
         pair_stb  <= 1'b0;
      end else begin
         pair_stb <= 1'b0;
         if (rise) begin
            ws_prev   <= ws_s;
            chan_last <= chan;
            seen      <= 1'b1;
            sr        <= word_next;
            if (seen && chan != chan_last) begin
               locked <= 1'b1;
               cnt    <= CNT_W'(1);
            end else if (locked && cnt != CNT_FULL) begin
               cnt <= cnt + 1'b1;
            end
            if (word_done) begin
               if (is_left) begin
                  left_hold <= word_next;
                  have_left <= 1'b1;
               end else if (have_left) begin
                  pair_left  <= left_hold;
                  pair_right <= word_next;
                  pair_stb   <= 1'b1;
                  have_left  <= 1'b0;
               end
            end
         end
      end
   end

   // R10
   pair_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_stb |=> !pair_stb);

endmodule

// File: rtl/audio_route_sel.sv
module audio_route_sel
   import audio_route_pkg::*;
#(
   parameter int SAMPLE_W    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [3:0]           route_code,
   input  logic [3:0]           fmt_code,
   input  logic [SAMPLE_W-1:0]  dec_left,
   input  logic [SAMPLE_W-1:0]  dec_right,
   input  logic                 dec_valid,
   input  logic                 ser_bclk_in,
   input  logic                 ser_ws_in,
   input  logic                 ser_data_in,
   output logic [SAMPLE_W-1:0]  dac_left,
   output logic [SAMPLE_W-1:0]  dac_right,
   output logic                 dac_valid,
   output logic [3:0]           ser_out_oe
);

   generate
      if (SAMPLE_W < 2) begin : g_bad_width
         $error("audio_route_sel: SAMPLE_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("audio_route_sel: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [2:0]          pins_s;
   frame_e              frame;
   logic                direct_ok;
   path_e               path;
   logic [SAMPLE_W-1:0] lb_left;
   logic [SAMPLE_W-1:0] lb_right;
   logic                lb_stb;

   ar_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_bclk_in, ser_ws_in, ser_data_in}),
      .q     (pins_s)
   );

   ar_fmt_decode u_fmt (
      .fmt_code  (fmt_code),
      .frame     (frame),
      .direct_ok (direct_ok)
   );

   assign path = route_decode(route_code, direct_ok);

   ar_lb_deser #(.SAMPLE_W(SAMPLE_W)) u_deser (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (path == PATH_LOOP),
      .frame      (frame),
      .bclk_s     (pins_s[2]),
      .ws_s       (pins_s[1]),
      .sd_s       (pins_s[0]),
      .pair_left  (lb_left),
      .pair_right (lb_right),
      .pair_stb   (lb_stb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_left   <= '0;
         dac_right  <= '0;
         dac_valid  <= 1'b0;
         ser_out_oe <= '0;
      end else begin
         ser_out_oe <= (path == PATH_LOOP) ? '1 : '0;
         case (path)
            PATH_DIRECT: begin
               dac_valid <= dec_valid;
               if (dec_valid) begin
                  dac_left  <= dec_left;
                  dac_right <= dec_right;
               end
            end
            PATH_LOOP: begin
               dac_valid <= lb_stb;
               if (lb_stb) begin
                  dac_left  <= lb_left;
                  dac_right <= lb_right;
               end
            end
            default: begin
               dac_valid <= 1'b0;
               dac_left  <= '0;
               dac_right <= '0;
            end
         endcase
      end
   end

   // R1
   direct_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (path == PATH_DIRECT && dec_valid) |=>
         (dac_valid && dac_left == $past(dec_left) && dac_right == $past(dec_right)));

   // R2
   pins_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route_code != ROUTE_LOOP) |=> (ser_out_oe == 4'b0000));

   // R3
   pins_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route_code == ROUTE_LOOP) |=> (ser_out_oe == 4'b1111));

   // R6
   direct_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route_code == ROUTE_DIRECT && !direct_ok) |=>
         (!dac_valid && dac_left == '0 && dac_right == '0));

   // R7
   route_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route_code != ROUTE_LOOP && route_code != ROUTE_DIRECT) |=>
         (!dac_valid && dac_left == '0 && dac_right == '0));

   // R8
   loop_ignores_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (path == PATH_LOOP && !lb_stb) |=> !dac_valid);

endmodule

// File: tb/audio_route_sel_bench.sv
module audio_route_sel_bench;

   localparam int W  = 16;
   localparam int HP = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   route_code = 4'b0101;
   logic [3:0]   fmt_code = 4'b0010;
   logic [W-1:0] dec_left = '0;
   logic [W-1:0] dec_right = '0;
   logic         dec_valid = 1'b0;
   logic         ser_bclk_in = 1'b0;
   logic         ser_ws_in = 1'b0;
   logic         ser_data_in = 1'b0;
   logic [W-1:0] dac_left;
   logic [W-1:0] dac_right;
   logic         dac_valid;
   logic [3:0]   ser_out_oe;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic prev_bit = 1'b0;

   logic [2*W-1:0] exp_q[$];
   string          tag_q[$];

   always #10 clk = ~clk;

   audio_route_sel #(.SAMPLE_W(W), .SYNC_STAGES(2)) u_audio_route_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .route_code  (route_code),
      .fmt_code    (fmt_code),
      .dec_left    (dec_left),
      .dec_right   (dec_right),
      .dec_valid   (dec_valid),
      .ser_bclk_in (ser_bclk_in),
      .ser_ws_in   (ser_ws_in),
      .ser_data_in (ser_data_in),
      .dac_left    (dac_left),
      .dac_right   (dac_right),
      .dac_valid   (dac_valid),
      .ser_out_oe  (ser_out_oe)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every strobe
   always @(posedge clk) begin
      #2;
      if (rst_n && dac_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected strobe", {dac_left, dac_right}, '0);
         end else begin
            logic [2*W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({dac_left, dac_right} == e, t, {dac_left, dac_right}, e);
         end
      end
   end

   task automatic dec_push(input logic [W-1:0] l, input logic [W-1:0] r,
                           input bit expect_it, input string tag);
      @(negedge clk);
      dec_left  = l;
      dec_right = r;
      dec_valid = 1'b1;
      if (expect_it) begin
         exp_q.push_back({l, r});
         tag_q.push_back(tag);
      end
      @(negedge clk);
      dec_valid = 1'b0;
   endtask

   task automatic slot(input logic ws, input logic d);
      @(negedge clk);
      ser_bclk_in = 1'b0;
      ser_ws_in   = ws;
      ser_data_in = d;
      repeat (HP - 1) @(negedge clk);
      @(negedge clk);
      ser_bclk_in = 1'b1;
      repeat (HP - 1) @(negedge clk);
   endtask

   // word clock high = left, MSB in first slot of each half
   task automatic frame_plain(input logic [W-1:0] l, input logic [W-1:0] r,
                              input bit expect_it, input string tag);
      logic [2*W-1:0] bits;
      bits = {l, r};
      if (expect_it) begin
         exp_q.push_back(bits);
         tag_q.push_back(tag);
      end
      for (int k = 0; k < 2 * W; k++) slot(k < W, bits[2*W-1-k]);
   endtask

   // word clock low = left, MSB one slot after the word clock edge
   task automatic frame_i2s(input logic [W-1:0] l, input logic [W-1:0] r,
                            input bit expect_it, input string tag);
      logic [2*W-1:0] bits;
      bits = {l, r};
      if (expect_it) begin
         exp_q.push_back(bits);
         tag_q.push_back(tag);
      end
      for (int k = 0; k < 2 * W; k++)
         slot(k >= W, (k == 0) ? prev_bit : bits[2*W-k]);
      prev_bit = r[0];
   endtask

   task automatic drain(input string tag);
      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, tag, 32'(exp_q.size()), '0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check(dac_valid == 1'b0, "R9 valid", 32'(dac_valid), 0);
      check({dac_left, dac_right} == '0, "R9 data", {dac_left, dac_right}, 0);
      check(ser_out_oe == 4'b0000, "R9 oe", 32'(ser_out_oe), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 / R2 direct path, format 0010
      route_code = 4'b0010;
      fmt_code   = 4'b0010;
      repeat (2) @(negedge clk);
      check(ser_out_oe == 4'b0000, "R2 direct oe", 32'(ser_out_oe), 0);
      dec_push(16'h1234, 16'hABCD, 1'b1, "R1 pair a");
      dec_push(16'hFFFF, 16'h0000, 1'b1, "R1 pair b");
      dec_push(16'h8000, 16'h0001, 1'b1, "R1 pair c");
      // R8 serial input ignored in direct mode
      frame_plain(16'h5555, 16'hAAAA, 1'b0, "");
      frame_plain(16'h0F0F, 16'hF0F0, 1'b0, "");
      drain("R8 direct ignores serial");
      fmt_code = 4'b1010;
      repeat (2) @(negedge clk);
      dec_push(16'h0BAD, 16'hCAFE, 1'b1, "R1 cdrom fmt");
      drain("R1 drained");

      // R6 refused direct
      fmt_code = 4'b0110;
      dec_push(16'h7777, 16'h8888, 1'b0, "");
      repeat (3) @(negedge clk);
      check({dac_left, dac_right} == '0 && !dac_valid, "R6 refused",
            {dac_left, dac_right}, 0);
      check(ser_out_oe == 4'b0000, "R2 refused oe", 32'(ser_out_oe), 0);

      // R7 other route
      fmt_code   = 4'b0010;
      route_code = 4'b0101;
      dec_push(16'h1111, 16'h2222, 1'b0, "");
      repeat (3) @(negedge clk);
      check({dac_left, dac_right} == '0 && !dac_valid, "R7 off",
            {dac_left, dac_right}, 0);
      check(ser_out_oe == 4'b0000, "R7 oe", 32'(ser_out_oe), 0);

      // R3 / R4 / R5 loopback, plain framing
      route_code = 4'b0000;
      repeat (2) @(negedge clk);
      check(ser_out_oe == 4'b1111, "R3 loop oe", 32'(ser_out_oe), 32'hF);
      frame_plain(16'hDEAD, 16'hBEEF, 1'b0, "");
      frame_plain(16'h1357, 16'h2468, 1'b1, "R4 plain a");
      dec_push(16'h4444, 16'h5555, 1'b0, "");
      frame_plain(16'hFFFF, 16'h0001, 1'b1, "R5 plain b");
      frame_plain(16'h8000, 16'h7FFF, 1'b1, "R4 plain c");
      drain("R4 plain drained");

      // R5 loopback, I2S-style framing
      route_code = 4'b0101;
      fmt_code   = 4'b1110;
      repeat (3) @(negedge clk);
      route_code = 4'b0000;
      prev_bit   = 1'b0;
      repeat (2) @(negedge clk);
      frame_i2s(16'h0000, 16'h0000, 1'b0, "");
      frame_i2s(16'hC001, 16'h0FF0, 1'b1, "R5 i2s a");
      frame_i2s(16'h0001, 16'h8000, 1'b1, "R5 i2s b");
      dec_push(16'h6666, 16'h9999, 1'b0, "");
      frame_i2s(16'hA5A5, 16'h5A5B, 1'b1, "R10 i2s c");
      slot(1'b0, prev_bit);
      slot(1'b0, 1'b0);
      drain("R5 i2s drained");
      check(ser_out_oe == 4'b1111, "R3 loop oe end", 32'(ser_out_oe), 32'hF);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule